// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block performs one multiply-accumulate step on a 64-bit accumulator that is handed to it as a high word and a low word. It fetches its two operands itself. It issues one read at the address held in the first pointer, then one read at the address held in the second pointer. Each pointer is advanced by the operand size after its read. The operands are multiplied as signed values, and the product is added to the accumulator. The new accumulator halves and the advanced pointers are returned, and a one-cycle completion pulse marks them valid.

There are two operand widths. In long mode the block multiplies two signed 32-bit operands into a full 64-bit product. In word mode it multiplies two signed 16-bit operands, each sign-extended to 32 bits first. A saturation enable selects a clamping rule, and each mode has its own rule. In long mode the result is held to a 48-bit signed span, with special clamp words. In word mode it is held to a 32-bit signed span. With saturation off, the sum wraps modulo 2^64.

The enclosing core starts the block with a single-cycle start strobe, together with the mode, the saturation enable, the pointers and the accumulator. All of these inputs are latched on that strobe.

Top module: `mac_sat_unit`

## Requirements
- R1: The first read request carries the address latched from `ptrAIn` and the second carries the address latched from `ptrBIn`. Only one request is outstanding at a time. A request holds `memReqValid` and its address until it is accepted with `memReqReady`, and the next request is issued only after the response to the previous one has been received.
- R2: `memReqSize` is 1 (two bytes) in word mode and 2 (four bytes) in long mode. Returned data is right-aligned, so word mode uses only bits 15:0 of `memRspData` and ignores bits 31:16.
- R3: `ptrAOut` and `ptrBOut` equal the latched pointers plus 4 in long mode or plus 2 in word mode, modulo 2^ADDR_W.
- R4: In word mode, both 16-bit operands are sign-extended and multiplied, and the signed product is added to the full 64-bit accumulator {accHiIn, accLoIn}.
- R5: In long mode, the full signed 64-bit product of the two 32-bit operands is added to the accumulator.
- R6: With `satEn` low, no clamping is applied in either mode, and the 64-bit sum wraps modulo 2^64.
- R7: In long mode with `satEn` high, bits 63:48 of the accumulator are cleared before the product is added.
- R8: In long mode with `satEn` high, if the result's high word is negative and, compared as unsigned, is below 0xFFFF8000, the output becomes high 0x00008000 and low 0x00000000.
- R9: In long mode with `satEn` high, if the result's high word is positive and above 0x00007FFF, the output becomes high 0x00007FFF and low 0xFFFFFFFF.
- R10: In word mode with `satEn` high, a result below -2^31 gives high 0xFFFFFFFF and low 0x80000000, and a result above 2^31-1 gives high 0x7FFFFFFF and low 0xFFFFFFFF.
- R11: `done` is high exactly LAT_LONG cycles (default 3) after the cycle in which the second response is presented in long mode, and exactly LAT_WORD cycles (default 2) after it in word mode.
- R12: `done` is high for exactly one cycle per operation. A `start` pulse while an operation is in progress is ignored: it changes neither that operation's results nor its pointers, and it launches no further request.
- R13: During and right after reset, `done` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| opLong | input | 1 | 1 selects long mode, 0 selects word mode |
| satEn | input | 1 | Saturation enable |
| ptrAIn | input | ADDR_W | Pointer to the first operand |
| ptrBIn | input | ADDR_W | Pointer to the second operand |
| accHiIn | input | 32 | Accumulator high word |
| accLoIn | input | 32 | Accumulator low word |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | ADDR_W | Read byte address |
| memReqSize | output | 2 | Size code: 1 for two bytes, 2 for four bytes |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Right-aligned read data |
| accHiOut | output | 32 | New accumulator high word |
| accLoOut | output | 32 | New accumulator low word |
| ptrAOut | output | ADDR_W | Advanced first pointer |
| ptrBOut | output | ADDR_W | Advanced second pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with ADDR_W set to 16 and keeps the default latencies of 3 and 2. The narrow address width lets a long-mode pointer at 0xFFFC wrap to 0x0000 in a short run, which exercises the modulo rule of R3. The default latencies make the exact `done` cycle checkable against a behavioural count, for both modes and under varied ready and response delays.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

  typedef struct packed {
    logic load;     // latch configuration, pointers, accumulator
    logic capA;     // first operand returned
    logic capB;     // second operand returned
    logic mulStep;  // long product register update
    logic finStep;  // accumulate and saturate into result
  } macStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_WAIT_A,
    ST_REQ_B,
    ST_WAIT_B,
    ST_EXEC
  } macState_t;

  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_FULL = 2'd2;

  localparam logic [63:0] LONG_NEG_CLAMP = 64'h00008000_00000000;
  localparam logic [63:0] LONG_POS_CLAMP = 64'h00007FFF_FFFFFFFF;
  localparam logic [63:0] WORD_NEG_CLAMP = 64'hFFFFFFFF_80000000;
  localparam logic [63:0] WORD_POS_CLAMP = 64'h7FFFFFFF_FFFFFFFF;

endpackage

// File: rtl/mac_sat_ctrl.sv
module mac_sat_ctrl
  import mac_sat_pkg::*;
#(
  parameter int LAT_LONG = 3,
  parameter int LAT_WORD = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cfgLong,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        memReqValid,
  output logic        reqSelB,
  output logic        busy,
  output logic        done,
  output macStrobes_t strobes
);

  localparam int LAT_MAX = (LAT_LONG > LAT_WORD) ? LAT_LONG : LAT_WORD;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LONG = CNT_W'(LAT_LONG - 1);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(LAT_WORD - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  macState_t        state;
  logic [CNT_W-1:0] execCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      execCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (start) state <= ST_REQ_A;
        ST_REQ_A:  if (memReqReady) state <= ST_WAIT_A;
        ST_WAIT_A: if (memRspValid) state <= ST_REQ_B;
        ST_REQ_B:  if (memReqReady) state <= ST_WAIT_B;
        ST_WAIT_B: if (memRspValid) begin
          state   <= ST_EXEC;
          execCnt <= cfgLong ? CNT_LONG : CNT_WORD;
        end
        ST_EXEC: begin
          if (execCnt == '0) state <= ST_IDLE;
          else execCnt <= execCnt - CNT_ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memReqValid     = (state == ST_REQ_A) || (state == ST_REQ_B);
    reqSelB         = (state == ST_REQ_B) || (state == ST_WAIT_B);
    busy            = (state != ST_IDLE);
    done            = (state == ST_EXEC) && (execCnt == '0);
    strobes.load    = (state == ST_IDLE) && start;
    strobes.capA    = (state == ST_WAIT_A) && memRspValid;
    strobes.capB    = (state == ST_WAIT_B) && memRspValid;
    strobes.mulStep = (state == ST_EXEC) && cfgLong && (execCnt == CNT_LONG);
    strobes.finStep = (state == ST_EXEC) && (execCnt == CNT_ONE);
  end

  // R12: completion pulse lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: an unaccepted request stays up and keeps its target
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(reqSelB)));

  // R11: completion never directly follows the second response
  p_no_early_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capB |=> (busy && !done));

  // R12: a start pulse during an operation does not restart it
  p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);

endmodule

// File: rtl/mac_sat_dp.sv
module mac_sat_dp
  import mac_sat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  macStrobes_t       strobes,
  input  logic              startLong,
  input  logic              startSat,
  input  logic [ADDR_W-1:0] ptrAIn,
  input  logic [ADDR_W-1:0] ptrBIn,
  input  logic [31:0]       accHiIn,
  input  logic [31:0]       accLoIn,
  input  logic [31:0]       memRspData,
  input  logic              reqSelB,
  output logic              cfgLong,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [1:0]        memReqSize,
  output logic [31:0]       accHiOut,
  output logic [31:0]       accLoOut,
  output logic [ADDR_W-1:0] ptrAOut,
  output logic [ADDR_W-1:0] ptrBOut
);

  logic              cfgSat;
  logic [ADDR_W-1:0] ptrA, ptrB;
  logic [31:0]       opA, opB;
  logic [63:0]       accBase, prodReg, resReg;
  logic [ADDR_W-1:0] ptrStep;
  logic [63:0]       startAcc;
  logic signed [63:0] longProd, wordProd, addend, sum;
  logic [31:0]       sumHi;
  logic [63:0]       satRes;

  assign ptrStep = cfgLong ? ADDR_W'(4) : ADDR_W'(2);

  always_comb begin
    startAcc = {accHiIn, accLoIn};
    if (startLong && startSat) startAcc[63:48] = 16'h0000;
  end

  always_comb begin
    longProd = $signed({{32{opA[31]}}, opA}) * $signed({{32{opB[31]}}, opB});
    wordProd = $signed({{48{opA[15]}}, opA[15:0]}) * $signed({{48{opB[15]}}, opB[15:0]});
    addend   = cfgLong ? $signed(prodReg) : wordProd;
    sum      = $signed(accBase) + addend;
    sumHi    = sum[63:32];
    satRes   = sum;
    if (cfgSat) begin
      if (cfgLong) begin
        if (sumHi[31] && (sumHi < 32'hFFFF8000))       satRes = LONG_NEG_CLAMP;
        else if (!sumHi[31] && (sumHi > 32'h00007FFF)) satRes = LONG_POS_CLAMP;
      end else begin
        if (sum < $signed(WORD_NEG_CLAMP))             satRes = WORD_NEG_CLAMP;
        else if (sum > $signed(64'h00000000_7FFFFFFF)) satRes = WORD_POS_CLAMP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgLong <= 1'b0;
      cfgSat  <= 1'b0;
      ptrA    <= '0;
      ptrB    <= '0;
      opA     <= '0;
      opB     <= '0;
      accBase <= '0;
      prodReg <= '0;
      resReg  <= '0;
    end else begin
      if (strobes.load) begin
        cfgLong <= startLong;
        cfgSat  <= startSat;
        ptrA    <= ptrAIn;
        ptrB    <= ptrBIn;
        accBase <= startAcc;
      end
      if (strobes.capA) begin
        opA  <= memRspData;
        ptrA <= ptrA + ptrStep;
      end
      if (strobes.capB) begin
        opB  <= memRspData;
        ptrB <= ptrB + ptrStep;
      end
      if (strobes.mulStep) prodReg <= longProd;
      if (strobes.finStep) resReg  <= satRes;
    end
  end

  assign memReqAddr = reqSelB ? ptrB : ptrA;
  assign memReqSize = cfgLong ? SIZE_FULL : SIZE_HALF;
  assign accHiOut   = resReg[63:32];
  assign accLoOut   = resReg[31:0];
  assign ptrAOut    = ptrA;
  assign ptrBOut    = ptrB;

  // R8, R9: long saturated result stays in the 48-bit span or is the negative clamp
  p_long_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.finStep && cfgLong && cfgSat) |=>
      (($signed(resReg[63:32]) >= $signed(32'hFFFF8000)) &&
       ($signed(resReg[63:32]) <= $signed(32'h00007FFF))) ||
      (resReg == LONG_NEG_CLAMP));

  // R10: word saturated result fits 32 signed bits or is the positive clamp
  p_word_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.finStep && !cfgLong && cfgSat) |=>
      (resReg[63:32] == {32{resReg[31]}}) || (resReg == WORD_POS_CLAMP));

  // R3: a pointer moves only when its operand is captured
  p_ptr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.load && !strobes.capA) |=> $stable(ptrA));

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LAT_LONG = 3,
  parameter int LAT_WORD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              opLong,
  input  logic              satEn,
  input  logic [ADDR_W-1:0] ptrAIn,
  input  logic [ADDR_W-1:0] ptrBIn,
  input  logic [31:0]       accHiIn,
  input  logic [31:0]       accLoIn,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [1:0]        memReqSize,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic [31:0]       accHiOut,
  output logic [31:0]       accLoOut,
  output logic [ADDR_W-1:0] ptrAOut,
  output logic [ADDR_W-1:0] ptrBOut,
  output logic              done
);

  macStrobes_t strobes;
  logic        cfgLong, reqSelB, busy;

  mac_sat_ctrl #(.LAT_LONG(LAT_LONG), .LAT_WORD(LAT_WORD)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfgLong(cfgLong),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memReqValid(memReqValid), .reqSelB(reqSelB), .busy(busy),
    .done(done), .strobes(strobes)
  );

  mac_sat_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .startLong(opLong), .startSat(satEn),
    .ptrAIn(ptrAIn), .ptrBIn(ptrBIn), .accHiIn(accHiIn), .accLoIn(accLoIn),
    .memRspData(memRspData), .reqSelB(reqSelB), .cfgLong(cfgLong),
    .memReqAddr(memReqAddr), .memReqSize(memReqSize),
    .accHiOut(accHiOut), .accLoOut(accLoOut),
    .ptrAOut(ptrAOut), .ptrBOut(ptrBOut)
  );

  // R2: size code follows the latched mode while a request is up
  p_size_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> (memReqSize == (cfgLong ? SIZE_FULL : SIZE_HALF)));

  // R13: no request and no completion outside an operation
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!memReqValid && !done));

endmodule

// File: tb/mac_sat_unit_tb_top.sv
module mac_sat_unit_tb_top;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, opLong = 1'b0, satEn = 1'b0;
  logic [AW-1:0] ptrAIn = '0, ptrBIn = '0;
  logic [31:0]   accHiIn = '0, accLoIn = '0;
  logic          memReqValid, memReqReady = 1'b0;
  logic [AW-1:0] memReqAddr;
  logic [1:0]    memReqSize;
  logic          memRspValid = 1'b0;
  logic [31:0]   memRspData = '0;
  logic [31:0]   accHiOut, accLoOut;
  logic [AW-1:0] ptrAOut, ptrBOut;
  logic          done;

  int  checks = 0;
  int  errors = 0;
  bit  doneAllowed = 1'b0;

  always #10 clk = ~clk;

  mac_sat_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opLong(opLong), .satEn(satEn),
    .ptrAIn(ptrAIn), .ptrBIn(ptrBIn), .accHiIn(accHiIn), .accLoIn(accLoIn),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqSize(memReqSize),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .accHiOut(accHiOut), .accLoOut(accLoOut),
    .ptrAOut(ptrAOut), .ptrBOut(ptrBOut), .done(done)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Every clock: done may only appear in the cycle the bench expects it (R12)
  always @(negedge clk) begin
    if (rst_n && done && !doneAllowed) begin
      checks++;
      errors++;
      $display("FAIL R12 unexpected done actual 1 expected 0");
    end
  end

  function automatic logic [63:0] refMac(bit isLong, bit sat, logic [63:0] acc,
                                         logic [31:0] a, logic [31:0] b);
    logic signed [63:0] pa, pb, s;
    logic [31:0] hi;
    if (isLong) begin
      pa = {{32{a[31]}}, a};
      pb = {{32{b[31]}}, b};
      if (sat) acc[63:48] = 16'h0;                       // R7
      s = $signed(acc) + pa * pb;                        // R5, R6
      hi = s[63:32];
      if (sat && hi[31] && hi < 32'hFFFF8000) s = 64'h00008000_00000000;       // R8
      else if (sat && !hi[31] && hi > 32'h00007FFF) s = 64'h00007FFF_FFFFFFFF; // R9
    end else begin
      pa = {{48{a[15]}}, a[15:0]};
      pb = {{48{b[15]}}, b[15:0]};
      s = $signed(acc) + pa * pb;                        // R4, R6
      if (sat && s < -64'sd2147483648) s = 64'hFFFFFFFF_80000000;              // R10
      else if (sat && s > 64'sd2147483647) s = 64'h7FFFFFFF_FFFFFFFF;          // R10
    end
    return s;
  endfunction

  task automatic runOp(string name, bit isLong, bit sat, logic [AW-1:0] rn,
                       logic [AW-1:0] rm, logic [63:0] acc, logic [31:0] a,
                       logic [31:0] b, int rdyWait, int rspWait, bit poke);
    logic [63:0]   expRes = refMac(isLong, sat, acc, a, b);
    logic [AW-1:0] step = isLong ? AW'(4) : AW'(2);
    int lat = isLong ? 3 : 2;
    @(negedge clk);
    start = 1'b1; opLong = isLong; satEn = sat;
    ptrAIn = rn; ptrBIn = rm; accHiIn = acc[63:32]; accLoIn = acc[31:0];
    @(negedge clk);
    start = 1'b0; opLong = ~isLong; satEn = ~sat;
    ptrAIn = 16'h5A5A; ptrBIn = 16'hA5A5; accHiIn = 32'hDEADBEEF; accLoIn = 32'h0BADF00D;
    for (int k = 0; k < 2; k++) begin
      while (!memReqValid) @(negedge clk);
      chk({name, " R1 address"}, 64'(memReqAddr), 64'(k == 0 ? rn : rm));
      chk({name, " R2 size"}, 64'(memReqSize), isLong ? 64'd2 : 64'd1);
      repeat (rdyWait) begin
        @(negedge clk);
        chk({name, " R1 held"}, 64'(memReqValid), 64'd1);
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      chk({name, " R1 single outstanding"}, 64'(memReqValid), 64'd0);
      repeat (rspWait) @(negedge clk);
      memRspValid = 1'b1;
      memRspData  = isLong ? (k == 0 ? a : b) : {16'hC3C3, (k == 0 ? a[15:0] : b[15:0])};
      if (poke && k == 0) begin
        start = 1'b1; ptrAIn = 16'h0100; ptrBIn = 16'h0200; opLong = 1'b1;
      end
      @(negedge clk);
      memRspValid = 1'b0;
      start = 1'b0;
    end
    for (int c = 1; c < lat; c++) begin
      chk({name, " R11 not yet done"}, 64'(done), 64'd0);
      @(negedge clk);
    end
    doneAllowed = 1'b1;
    chk({name, " R11 done on time"}, 64'(done), 64'd1);
    chk({name, " R4-result"}, {accHiOut, accLoOut}, expRes);
    chk({name, " R3 pointer A"}, 64'(ptrAOut), 64'(AW'(rn + step)));
    chk({name, " R3 pointer B"}, 64'(ptrBOut), 64'(AW'(rm + step)));
    @(negedge clk);
    doneAllowed = 1'b0;
    chk({name, " R12 single pulse"}, 64'(done), 64'd0);
    if (poke) begin
      repeat (3) begin
        chk({name, " R12 busy start ignored"}, 64'(memReqValid), 64'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R13 reset done", 64'(done), 64'd0);
      chk("R13 reset request", 64'(memReqValid), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 after reset request", 64'(memReqValid), 64'd0);

    runOp("R4 word plain", 0, 0, 16'h1000, 16'h2002, 64'h00000000_00000010,
          32'h0000FFFE, 32'h00000003, 0, 0, 0);
    runOp("R6 word wrap", 0, 0, 16'h0010, 16'h0020, 64'h7FFFFFFF_FFFFFFFF,
          32'h00000001, 32'h00000001, 1, 2, 0);
    runOp("R10 word pos clamp", 0, 1, 16'h0300, 16'h0400, 64'h00000000_7FFFFFF0,
          32'h00007FFF, 32'h00007FFF, 2, 1, 0);
    runOp("R10 word neg clamp", 0, 1, 16'h0500, 16'h0600, 64'hFFFFFFFF_80000005,
          32'h00008000, 32'h00000002, 0, 1, 0);
    runOp("R5 long plain", 1, 0, 16'h0700, 16'h0804, 64'h0,
          32'hFFFFFFFF, 32'h00000005, 1, 0, 0);
    runOp("R6 long keeps top", 1, 0, 16'h0900, 16'h0A00, 64'h12340000_00000001,
          32'h00000002, 32'h00000003, 0, 0, 0);
    runOp("R7 long clears top", 1, 1, 16'h0B00, 16'h0C00, 64'h12340000_00000001,
          32'h00000002, 32'h00000003, 0, 2, 0);
    runOp("R9 long pos clamp", 1, 1, 16'h0D00, 16'h0E00, 64'h00007FFF_00000000,
          32'h00010000, 32'h00010000, 2, 0, 0);
    runOp("R8 long neg clamp", 1, 1, 16'h0F00, 16'h1100, 64'h0,
          32'h80000000, 32'h00020000, 1, 1, 0);
    runOp("R8 long boundary kept", 1, 1, 16'h1200, 16'h1300, 64'h0,
          32'h80000000, 32'h00010000, 0, 0, 0);
    runOp("R3 long pointer wrap", 1, 0, 16'hFFFC, 16'hFFFE, 64'h00000000_00000003,
          32'h00000004, 32'hFFFFFFFE, 0, 0, 0);
    runOp("R12 busy start", 0, 1, 16'h1400, 16'h1500, 64'h0,
          32'h00001234, 32'h0000FF00, 1, 1, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule